// File: doc/BRIEF.md
# Typed Register Slave for a Packet Module

This block is an AXI4-Lite slave that owns the software-visible registers of one packet-processing module. Each of its seven 32-bit words has its own access behaviour. Some words are constants. One word reads back inverted. Two words are packet counters that clear when software reads them. One scratch word can be written by hardware as well as by software. One word is kept in network (big-endian) byte order. A bus read or write can therefore change state in ways a plain store would not.

The surrounding module drives two single-cycle pulses, one when a packet arrives and one when a packet leaves. It receives the current scratch value and the byte-swapped word as plain outputs. It can overwrite the scratch word through an enable-qualified port. The write address and write data channels are taken independently, and each channel holds one transaction at a time.

Top module: `axil_typed_regs`

## Requirements
- R1: The identity word at byte address 0x00 always reads 0x0000DA03 and the revision word at 0x04 always reads 0x00000001. Writes to either complete with OKAY and change nothing.
- R2: The invert word at 0x08 stores what software writes and reads back the bitwise complement of the stored value. It therefore reads 0xFFFFFFFF after reset.
- R3: The arrival counter at 0x0C and the departure counter at 0x10 each add one for every clock cycle in which their pulse input is high. The count sits in bits COUNT_W-1:0 (30:0 by default) and the overflow flag in bit 31. Bits in between read zero.
- R4: A read of a counter returns its current value, and the whole word is cleared to zero in the cycle the read is accepted. Writes to the counters have no effect.
- R5: When a counter read is accepted in the same cycle as a pulse, the clear wins and that pulse is not counted. Pulses in later cycles count from zero.
- R6: When the count field is all ones and a pulse arrives, the field wraps to zero and bit 31 is set. Bit 31 stays set through later pulses until the word is cleared by a read.
- R7: The scratch word at 0x14 (reset 0) can be read and written by software. When hw_scratch_we is high, hw_scratch_wdata is loaded on that edge, and it takes priority over a software write in the same cycle. hw_scratch always shows the stored value.
- R8: The network-order word at 0x18 is stored byte-swapped. Bus lane 0 (wdata[7:0]) lands in stored bits 31:24, and lane 3 lands in stored bits 7:0. A read swaps back, so software reads what it wrote. hw_netorder shows the stored, swapped value.
- R9: On the writable words (0x08, 0x14, 0x18), wstrb bit i gates bus lane i. A lane whose strobe is low keeps its old byte.
- R10: The write address and write data can arrive in either order, with any gap between them. The write takes effect once both are held, and exactly one write response follows.
- R11: An access to a word index of 7 or more, or to an address whose two low bits are not zero, completes with SLVERR (2'b10) and changes nothing. A read of such an address returns zero. Mapped accesses answer OKAY (2'b00).
- R12: While rvalid is high, rdata and rresp stay constant until rready is seen. While bvalid is high, it stays high with a constant bresp until bready is seen.
- R13: The reset is active-low and sampled on the clock edge. It returns every stored word and both channels to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus and register clock |
| aresetn | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address slot free |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data slot free |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| pkt_rx_pulse | input | 1 | Packet arrival pulse |
| pkt_tx_pulse | input | 1 | Packet departure pulse |
| hw_scratch_we | input | 1 | Hardware write enable for the scratch word |
| hw_scratch_wdata | input | 32 | Hardware write value for the scratch word |
| hw_scratch | output | 32 | Current scratch value |
| hw_netorder | output | 32 | Current network-order word as stored |

## Verification
The assertions check the following on every cycle:
- the clear of a counter,
- the counter wrap into the overflow flag,
- the stickiness of that flag,
- the hardware load of the scratch word,
- the holding of read and write responses while the master stalls,
- the zero data on error reads.

Only the directed scenarios can show which value each address returns: the inverted and byte-swapped views, the strobe merging, the ignored writes to constants, and the order of the write channels. The same holds for the cycle-exact loss of a pulse that coincides with a counter read, because the bench must line up a read handshake and a pulse on one edge.

// File: rtl/typed_regs_pkg.sv
package typed_regs_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned LANES    = WORD_W / 8;
   localparam int unsigned NUM_REGS = 7;

   localparam int unsigned REG_IDENT  = 0;
   localparam int unsigned REG_REV    = 1;
   localparam int unsigned REG_INVERT = 2;
   localparam int unsigned REG_RXCNT  = 3;
   localparam int unsigned REG_TXCNT  = 4;
   localparam int unsigned REG_SCRAT  = 5;
   localparam int unsigned REG_NETORD = 6;

   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_SLVERR = 2'b10
   } resp_t;
endpackage

// File: rtl/typed_regs_wr_chan.sv
module typed_regs_wr_chan
   import typed_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   awaddr,
   input  logic                awvalid,
   output logic                awready,
   input  logic [WORD_W-1:0]   wdata,
   input  logic [LANES-1:0]    wstrb,
   input  logic                wvalid,
   output logic                wready,
   output logic                bvalid,
   output logic [1:0]          bresp,
   input  logic                bready,
   output logic                commit,
   output logic [ADDR_W-1:0]   cm_addr,
   output logic [WORD_W-1:0]   cm_data,
   output logic [LANES-1:0]    cm_strb,
   input  logic                cm_hit
);
   logic aw_full, w_full;

   assign awready = !aw_full;
   assign wready  = !w_full;
   assign commit  = aw_full && w_full && !bvalid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_full <= 1'b0;
         w_full  <= 1'b0;
         cm_addr <= '0;
         cm_data <= '0;
         cm_strb <= '0;
         bvalid  <= 1'b0;
         bresp   <= RESP_OKAY;
      end else begin
         if (awvalid && awready) begin
            aw_full <= 1'b1;
            cm_addr <= awaddr;
         end
         if (wvalid && wready) begin
            w_full  <= 1'b1;
            cm_data <= wdata;
            cm_strb <= wstrb;
         end
         if (commit) begin
            aw_full <= 1'b0;
            w_full  <= 1'b0;
            bvalid  <= 1'b1;
            bresp   <= cm_hit ? RESP_OKAY : RESP_SLVERR;
         end else if (bvalid && bready) begin
            bvalid  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/typed_regs_rd_chan.sv
module typed_regs_rd_chan
   import typed_regs_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arvalid,
   output logic               arready,
   output logic               take,
   input  logic [WORD_W-1:0]  lookup_data,
   input  logic               lookup_hit,
   output logic               rvalid,
   output logic [WORD_W-1:0]  rdata,
   output logic [1:0]         rresp,
   input  logic               rready
);
   assign arready = !rvalid;
   assign take    = arvalid && arready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
         rresp  <= RESP_OKAY;
      end else if (take) begin
         rvalid <= 1'b1;
         rdata  <= lookup_hit ? lookup_data : '0;
         rresp  <= lookup_hit ? RESP_OKAY : RESP_SLVERR;
      end else if (rvalid && rready) begin
         rvalid <= 1'b0;
      end
   end
endmodule

// File: rtl/typed_regs_pkt_counter.sv
module typed_regs_pkt_counter
   import typed_regs_pkg::*;
#(
   parameter int unsigned COUNT_W = 31
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inc,
   input  logic               clr,
   output logic [WORD_W-1:0]  value
);
   localparam int unsigned PAD_W = WORD_W - 1 - COUNT_W;

   if (COUNT_W < 1 || COUNT_W > WORD_W - 1) begin : g_bad_width
      $error("typed_regs_pkt_counter: COUNT_W out of range");
   end

   logic [COUNT_W-1:0] count_q;
   logic               ovf_q;
   logic               carry;
   logic [COUNT_W-1:0] count_nx;

   assign {carry, count_nx} = {1'b0, count_q} + {{COUNT_W{1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else if (inc) begin
         count_q <= count_nx;
         ovf_q   <= ovf_q | carry;
      end
   end

   if (PAD_W > 0) begin : g_pad
      assign value = {ovf_q, {PAD_W{1'b0}}, count_q};
   end else begin : g_nopad
      assign value = {ovf_q, count_q};
   end
endmodule

// File: rtl/axil_typed_regs.sv
module axil_typed_regs
   import typed_regs_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned COUNT_W   = 31,
   parameter logic [31:0] IDENT_VAL = 32'h0000_DA03,
   parameter logic [31:0] REV_VAL   = 32'h0000_0001
) (
   input  logic                aclk,
   input  logic                aresetn,
   input  logic [ADDR_W-1:0]   s_awaddr,
   input  logic                s_awvalid,
   output logic                s_awready,
   input  logic [31:0]         s_wdata,
   input  logic [3:0]          s_wstrb,
   input  logic                s_wvalid,
   output logic                s_wready,
   output logic [1:0]          s_bresp,
   output logic                s_bvalid,
   input  logic                s_bready,
   input  logic [ADDR_W-1:0]   s_araddr,
   input  logic                s_arvalid,
   output logic                s_arready,
   output logic [31:0]         s_rdata,
   output logic [1:0]          s_rresp,
   output logic                s_rvalid,
   input  logic                s_rready,
   input  logic                pkt_rx_pulse,
   input  logic                pkt_tx_pulse,
   input  logic                hw_scratch_we,
   input  logic [31:0]         hw_scratch_wdata,
   output logic [31:0]         hw_scratch,
   output logic [31:0]         hw_netorder
);
   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam int unsigned N_CNT = 2;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("axil_typed_regs: ADDR_W too small for the map");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("axil_typed_regs: word width must be 32");
   end

   // ---------------- write path ----------------
   logic               wr_commit, wr_hit;
   logic [ADDR_W-1:0]  wr_addr;
   logic [WORD_W-1:0]  wr_data;
   logic [LANES-1:0]   wr_strb;
   logic [IDX_W-1:0]   wr_word;

   typed_regs_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
      .clk(aclk), .rst_n(aresetn),
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
      .bvalid(s_bvalid), .bresp(s_bresp), .bready(s_bready),
      .commit(wr_commit), .cm_addr(wr_addr), .cm_data(wr_data),
      .cm_strb(wr_strb), .cm_hit(wr_hit)
   );

   assign wr_word = wr_addr[ADDR_W-1:2];
   assign wr_hit  = (wr_addr[1:0] == 2'b00) && (wr_word < IDX_W'(NUM_REGS));

   logic sw_inv, sw_scr, sw_net;
   assign sw_inv = wr_commit && wr_hit && (wr_word == IDX_W'(REG_INVERT));
   assign sw_scr = wr_commit && wr_hit && (wr_word == IDX_W'(REG_SCRAT));
   assign sw_net = wr_commit && wr_hit && (wr_word == IDX_W'(REG_NETORD));

   logic [WORD_W-1:0] inv_q, scr_q, net_q;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      localparam int unsigned SWAP = LANES - 1 - b;
      always_ff @(posedge aclk) begin
         if (!aresetn) begin
            inv_q[8*b +: 8]    <= '0;
            scr_q[8*b +: 8]    <= '0;
            net_q[8*SWAP +: 8] <= '0;
         end else begin
            if (sw_inv && wr_strb[b])
               inv_q[8*b +: 8] <= wr_data[8*b +: 8];
            if (hw_scratch_we)
               scr_q[8*b +: 8] <= hw_scratch_wdata[8*b +: 8];
            else if (sw_scr && wr_strb[b])
               scr_q[8*b +: 8] <= wr_data[8*b +: 8];
            if (sw_net && wr_strb[b])
               net_q[8*SWAP +: 8] <= wr_data[8*b +: 8];
         end
      end
   end

   assign hw_scratch  = scr_q;
   assign hw_netorder = net_q;

   // ---------------- read path ----------------
   logic               rd_take, rd_hit;
   logic [IDX_W-1:0]   rd_word;
   logic [WORD_W-1:0]  rd_mux, net_view;

   assign rd_word = s_araddr[ADDR_W-1:2];
   assign rd_hit  = (s_araddr[1:0] == 2'b00) && (rd_word < IDX_W'(NUM_REGS));

   for (genvar b = 0; b < LANES; b++) begin : g_unswap
      assign net_view[8*b +: 8] = net_q[8*(LANES-1-b) +: 8];
   end

   // ---------------- packet counters ----------------
   logic [N_CNT-1:0]  cnt_inc, cnt_clr;
   logic [WORD_W-1:0] cnt_val [N_CNT];

   assign cnt_inc = {pkt_tx_pulse, pkt_rx_pulse};

   for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
      localparam int unsigned MY_REG = (g == 0) ? REG_RXCNT : REG_TXCNT;
      assign cnt_clr[g] = rd_take && rd_hit && (rd_word == IDX_W'(MY_REG));
      typed_regs_pkt_counter #(.COUNT_W(COUNT_W)) u_cnt (
         .clk(aclk), .rst_n(aresetn),
         .inc(cnt_inc[g]), .clr(cnt_clr[g]), .value(cnt_val[g])
      );
   end

   always_comb begin
      rd_mux = '0;
      case (rd_word)
         IDX_W'(REG_IDENT):  rd_mux = IDENT_VAL;
         IDX_W'(REG_REV):    rd_mux = REV_VAL;
         IDX_W'(REG_INVERT): rd_mux = ~inv_q;
         IDX_W'(REG_RXCNT):  rd_mux = cnt_val[0];
         IDX_W'(REG_TXCNT):  rd_mux = cnt_val[1];
         IDX_W'(REG_SCRAT):  rd_mux = scr_q;
         IDX_W'(REG_NETORD): rd_mux = net_view;
         default:            rd_mux = '0;
      endcase
   end

   typed_regs_rd_chan u_rd (
      .clk(aclk), .rst_n(aresetn),
      .arvalid(s_arvalid), .arready(s_arready), .take(rd_take),
      .lookup_data(rd_mux), .lookup_hit(rd_hit),
      .rvalid(s_rvalid), .rdata(s_rdata), .rresp(s_rresp), .rready(s_rready)
   );
endmodule

// File: rtl/typed_regs_chk.sv
module typed_regs_chk
   import typed_regs_pkg::*;
#(
   parameter int unsigned COUNT_W = 31
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bvalid,
   input logic               bready,
   input logic [1:0]         bresp,
   input logic               rvalid,
   input logic               rready,
   input logic [WORD_W-1:0]  rdata,
   input logic [1:0]         rresp,
   input logic               rx_inc,
   input logic               rx_clr,
   input logic [WORD_W-1:0]  rx_val,
   input logic               tx_inc,
   input logic               tx_clr,
   input logic [WORD_W-1:0]  tx_val,
   input logic               hw_we,
   input logic [WORD_W-1:0]  hw_wdata,
   input logic [WORD_W-1:0]  hw_scratch
);
   // R4
   rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clr |=> (rx_val == '0));
   // R4
   tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clr |=> (tx_val == '0));
   // R6
   rx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_inc && !rx_clr && (&rx_val[COUNT_W-1:0]))
      |=> (rx_val[WORD_W-1] && (rx_val[COUNT_W-1:0] == '0)));
   // R6
   tx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_val[WORD_W-1] && !tx_clr) |=> tx_val[WORD_W-1]);
   // R7
   hw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_we |=> (hw_scratch == $past(hw_wdata)));
   // R12
   r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp)));
   // R12
   b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid && !bready) |=> (bvalid && $stable(bresp)));
   // R11
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && rresp == 2'b10) |-> (rdata == '0));
endmodule

bind axil_typed_regs typed_regs_chk #(.COUNT_W(COUNT_W)) u_chk (
   .clk(aclk), .rst_n(aresetn),
   .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
   .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
   .rx_inc(cnt_inc[0]), .rx_clr(cnt_clr[0]), .rx_val(cnt_val[0]),
   .tx_inc(cnt_inc[1]), .tx_clr(cnt_clr[1]), .tx_val(cnt_val[1]),
   .hw_we(hw_scratch_we), .hw_wdata(hw_scratch_wdata), .hw_scratch(hw_scratch)
);

// File: tb/axil_typed_regs_tb_top.sv
`timescale 1ns/1ps
module axil_typed_regs_tb_top;
   localparam int AW = 8;
   localparam int CW = 6;

   logic        aclk = 0;
   logic        aresetn = 0;
   logic [AW-1:0] s_awaddr = '0;
   logic        s_awvalid = 0, s_awready;
   logic [31:0] s_wdata = '0;
   logic [3:0]  s_wstrb = '0;
   logic        s_wvalid = 0, s_wready;
   logic [1:0]  s_bresp;
   logic        s_bvalid, s_bready = 0;
   logic [AW-1:0] s_araddr = '0;
   logic        s_arvalid = 0, s_arready;
   logic [31:0] s_rdata;
   logic [1:0]  s_rresp;
   logic        s_rvalid, s_rready = 0;
   logic        pkt_rx_pulse = 0, pkt_tx_pulse = 0;
   logic        hw_scratch_we = 0;
   logic [31:0] hw_scratch_wdata = '0;
   logic [31:0] hw_scratch, hw_netorder;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 aclk = ~aclk;

   axil_typed_regs #(.ADDR_W(AW), .COUNT_W(CW)) dut_i (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_aw(input logic [AW-1:0] a);
      @(negedge aclk); s_awaddr = a; s_awvalid = 1;
      while (!s_awready) @(negedge aclk);
      @(negedge aclk); s_awvalid = 0;
   endtask

   task automatic send_w(input logic [31:0] d, input logic [3:0] s);
      @(negedge aclk); s_wdata = d; s_wstrb = s; s_wvalid = 1;
      while (!s_wready) @(negedge aclk);
      @(negedge aclk); s_wvalid = 0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s,
                     input bit wfirst, input int gap, input int bhold, output logic [1:0] r);
      bit held = 1;
      if (!wfirst) begin
         send_aw(a); repeat (gap) @(negedge aclk); send_w(d, s);
      end else begin
         send_w(d, s); repeat (gap) @(negedge aclk); send_aw(a);
      end
      while (!s_bvalid) @(negedge aclk);
      r = s_bresp;
      for (int i = 0; i < bhold; i++) begin
         @(negedge aclk);
         if (!s_bvalid || s_bresp !== r) held = 0;
      end
      if (bhold > 0) check("R12 bvalid held", 32'(held), 32'd1);
      s_bready = 1; @(negedge aclk); s_bready = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input int hold,
                     output logic [31:0] d, output logic [1:0] r);
      bit held = 1;
      @(negedge aclk); s_araddr = a; s_arvalid = 1;
      while (!s_arready) @(negedge aclk);
      @(negedge aclk); s_arvalid = 0;
      while (!s_rvalid) @(negedge aclk);
      d = s_rdata; r = s_rresp;
      for (int i = 0; i < hold; i++) begin
         @(negedge aclk);
         if (!s_rvalid || s_rdata !== d || s_rresp !== r) held = 0;
      end
      if (hold > 0) check("R12 rdata held", 32'(held), 32'd1);
      s_rready = 1; @(negedge aclk); s_rready = 0;
   endtask

   task automatic pulse(input bit tx, input int n);
      @(negedge aclk);
      if (tx) pkt_tx_pulse = 1; else pkt_rx_pulse = 1;
      repeat (n) @(negedge aclk);
      pkt_tx_pulse = 0; pkt_rx_pulse = 0;
   endtask

   task automatic expect_rd(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      logic [31:0] d; logic [1:0] r;
      rd(a, 0, d, r);
      check(req, d, exp);
      check({req, " resp"}, 32'(r), 32'd0);
   endtask

   task automatic t_defaults(input string tag);
      expect_rd({tag, " R1 ident"}, 8'h00, 32'h0000DA03);
      expect_rd({tag, " R1 rev"}, 8'h04, 32'h00000001);
      expect_rd({tag, " R2 invert"}, 8'h08, 32'hFFFFFFFF);
      expect_rd({tag, " R3 rx"}, 8'h0C, 32'h0);
      expect_rd({tag, " R3 tx"}, 8'h10, 32'h0);
      expect_rd({tag, " R7 scratch"}, 8'h14, 32'h0);
      expect_rd({tag, " R8 netorder"}, 8'h18, 32'h0);
      check({tag, " R7 hw_scratch"}, hw_scratch, 32'h0);
      check({tag, " R8 hw_netorder"}, hw_netorder, 32'h0);
   endtask

   task automatic t_const;
      logic [1:0] r;
      wr(8'h00, 32'h12345678, 4'hF, 0, 0, 0, r);
      check("R1 write ident resp", 32'(r), 32'd0);
      wr(8'h04, 32'hFFFFFFFF, 4'hF, 0, 0, 0, r);
      expect_rd("R1 ident after write", 8'h00, 32'h0000DA03);
      expect_rd("R1 rev after write", 8'h04, 32'h00000001);
   endtask

   task automatic t_invert_strobe;
      logic [1:0] r;
      wr(8'h08, 32'h0F0F1234, 4'hF, 0, 0, 0, r);
      expect_rd("R2 invert readback", 8'h08, 32'hF0F0EDCB);
      wr(8'h08, 32'hAABBCCDD, 4'b0100, 0, 0, 0, r);
      expect_rd("R9 invert lane 2 only", 8'h08, 32'hF044EDCB);
   endtask

   task automatic t_netorder;
      logic [1:0] r;
      wr(8'h18, 32'h44332211, 4'hF, 0, 0, 0, r);
      check("R8 stored swapped", hw_netorder, 32'h11223344);
      expect_rd("R8 read unswapped", 8'h18, 32'h44332211);
      wr(8'h18, 32'h000000EE, 4'b0001, 0, 0, 0, r);
      check("R9 lane0 to msb", hw_netorder, 32'hEE223344);
      expect_rd("R9 netorder partial", 8'h18, 32'h443322EE);
   endtask

   task automatic t_order;
      logic [1:0] r;
      wr(8'h14, 32'h13572468, 4'hF, 1, 3, 0, r);
      check("R10 data first resp", 32'(r), 32'd0);
      expect_rd("R10 data first value", 8'h14, 32'h13572468);
      check("R7 hw_scratch follows sw", hw_scratch, 32'h13572468);
      wr(8'h14, 32'h9ABCDEF0, 4'hF, 0, 2, 3, r);
      check("R10 address first resp", 32'(r), 32'd0);
      expect_rd("R10 address first value", 8'h14, 32'h9ABCDEF0);
   endtask

   task automatic t_hw_scratch;
      logic [1:0] r;
      @(negedge aclk); hw_scratch_we = 1; hw_scratch_wdata = 32'h0BADF00D;
      @(negedge aclk); hw_scratch_we = 0;
      check("R7 hw load", hw_scratch, 32'h0BADF00D);
      expect_rd("R7 sw sees hw load", 8'h14, 32'h0BADF00D);
      @(negedge aclk); hw_scratch_we = 1; hw_scratch_wdata = 32'hCAFE0001;
      wr(8'h14, 32'h55555555, 4'hF, 0, 0, 0, r);
      @(negedge aclk); hw_scratch_we = 0;
      expect_rd("R7 hw wins over sw", 8'h14, 32'hCAFE0001);
   endtask

   task automatic t_counters;
      logic [1:0] r;
      pulse(0, 5); pulse(1, 3);
      expect_rd("R3 rx count", 8'h0C, 32'd5);
      expect_rd("R3 tx count", 8'h10, 32'd3);
      expect_rd("R4 rx cleared", 8'h0C, 32'd0);
      pulse(1, 2);
      wr(8'h10, 32'h0000_0030, 4'hF, 0, 0, 0, r);
      expect_rd("R4 tx write ignored", 8'h10, 32'd2);
      expect_rd("R4 tx cleared", 8'h10, 32'd0);
   endtask

   task automatic t_clear_race;
      logic [31:0] d;
      pulse(0, 4);
      @(negedge aclk); s_araddr = 8'h0C; s_arvalid = 1; pkt_rx_pulse = 1;
      @(negedge aclk); s_arvalid = 0;
      repeat (3) @(negedge aclk);
      pkt_rx_pulse = 0;
      d = s_rdata;
      s_rready = 1; @(negedge aclk); s_rready = 0;
      check("R5 value before clear", d, 32'd4);
      expect_rd("R5 pulse at clear lost", 8'h0C, 32'd3);
   endtask

   task automatic t_overflow;
      pulse(1, 64);
      pulse(1, 2);
      expect_rd("R6 wrap sticky flag", 8'h10, 32'h80000002);
      expect_rd("R6 flag cleared by read", 8'h10, 32'h0);
   endtask

   task automatic t_unmapped;
      logic [1:0] r; logic [31:0] d;
      wr(8'h1C, 32'hFFFFFFFF, 4'hF, 0, 0, 0, r);
      check("R11 write unmapped resp", 32'(r), 32'd2);
      wr(8'h16, 32'h11111111, 4'hF, 0, 0, 0, r);
      check("R11 write misaligned resp", 32'(r), 32'd2);
      rd(8'h80, 4, d, r);
      check("R11 read unmapped data", d, 32'h0);
      check("R11 read unmapped resp", 32'(r), 32'd2);
      expect_rd("R11 scratch untouched", 8'h14, 32'hCAFE0001);
   endtask

   task automatic t_reset;
      logic [1:0] r;
      wr(8'h14, 32'h77777777, 4'hF, 0, 0, 0, r);
      pulse(1, 3); pulse(0, 2);
      @(negedge aclk); aresetn = 0;
      repeat (2) @(negedge aclk);
      aresetn = 1;
      t_defaults("R13 after reset");
   endtask

   initial begin
      repeat (3) @(negedge aclk);
      aresetn = 1;
      t_defaults("R13 initial");
      t_const;
      t_invert_strobe;
      t_netorder;
      t_order;
      t_hw_scratch;
      t_counters;
      t_clear_race;
      t_overflow;
      t_unmapped;
      t_reset;
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge aclk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule